// File: doc/BRIEF.md
# Flash timing clock generator

This block produces the pacing tick for flash program and erase sequences. It picks one of three system clock sources, divides it by a programmable factor from 1 to 64, and emits a one-cycle tick on every completed division period. The three sources are modelled as enable strobes that are synchronous to a single reference clock. The tick is therefore a one-cycle pulse on that clock and never a separate clock net.

The generator runs only while the flash controller reports an operation in progress. When the controller raises `busy_i`, the block latches the source select and the divide field, and it keeps them for the whole operation. When busy drops, the divider returns to phase zero. A power-up clear or an emergency exit stops the generator at once. It then stays stopped until busy has fallen and risen again, so an aborted operation cannot resume in the middle of a period.

Top module: `ftg_top`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first rising edge of `busy_i`, `tick_o` is 0.
- R2: The select code is read as follows: 2'b00 uses `aux_stb_i`, 2'b01 uses `main_stb_i`, and both 2'b10 and 2'b11 use `sub_stb_i`. Strobes of the two sources that are not chosen never advance the divider.
- R3: With divide field value D, the divide factor is N = D + 1. D = 0 gives divide-by-1 and D = 63 gives divide-by-64. `tick_o` is high in the cycle after the clock edge that samples the N-th counted strobe of a period. The internal count never exceeds D.
- R4: The clock edge that first samples `busy_i` high after it was low starts a run. The first counted strobe is the one sampled at the following edge. Each run starts from phase zero. While `busy_i` is low, `tick_o` is 0 in the next cycle.
- R5: The select and divide inputs are captured at the edge that starts a run. Changes to them during the run have no effect on `tick_o`.
- R6: When `puc_i` is sampled high, `tick_o` is 0 in the next cycle and the divider clears. The generator stays stopped while `busy_i` stays high. It restarts only after `busy_i` is sampled low and then sampled high again.
- R7: When `emex_i` is sampled high, the generator stops in the same way as for `puc_i`. `tick_o` is 0 in the next cycle and the generator stays stopped until busy falls and rises again.
- R8: `tick_o` is high for exactly one cycle per division period. It is high in two consecutive cycles only when N = 1 and the chosen strobe was high at both edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aux_stb_i | input | 1 | Auxiliary clock enable strobe |
| main_stb_i | input | 1 | Main clock enable strobe |
| sub_stb_i | input | 1 | Sub-main clock enable strobe |
| src_sel_i | input | 2 | Source select code |
| div_i | input | 6 | Divide field (factor = value + 1) |
| busy_i | input | 1 | Operation in progress |
| puc_i | input | 1 | Power-up clear |
| emex_i | input | 1 | Emergency exit |
| tick_o | output | 1 | One-cycle timing tick |

## Verification
The three strobes run at different, coprime rates: main on every cycle, sub every third cycle and aux every fifth. A tick pattern that follows the wrong source therefore differs quickly from the expected one. All four select codes are tried, so the code 2'b11 is shown to alias code 2'b10. The divide fields used are 0, 1, 5 and 63. Together they separate an off-by-one factor, a counter that wraps early, and the continuous-tick case at divide-by-1. Runs where the select and divide inputs change mid-run, and runs that power-up clear and emergency exit cut short while busy stays high, separate configuration capture and stop-until-restart behaviour from a divider that only pauses.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  localparam int unsigned DIV_W   = 6;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_SRC = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_AUX  = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_SUB  = 2'b10,
    SRC_SUB2 = 2'b11
  } src_sel_e;

  localparam int unsigned IDX_AUX  = 0;
  localparam int unsigned IDX_MAIN = 1;
  localparam int unsigned IDX_SUB  = 2;
endpackage

// File: rtl/ftg_ctrl.sv
module ftg_ctrl
  import ftg_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          puc_i,
  input  logic          emex_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] div_i,
  output logic          run_o,
  output logic          clr_o,
  output logic [SW-1:0] sel_o,
  output logic [DW-1:0] div_o
);
  logic          busy_q;
  logic          run_q;
  logic [SW-1:0] sel_q;
  logic [DW-1:0] div_q;
  logic          stop;
  logic          start;

  assign stop  = puc_i | emex_i | ~busy_i;
  // start only on a busy edge; an aborted run waits for the next one
  assign start = busy_i & ~busy_q & ~puc_i & ~emex_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      sel_q  <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_i;
      if (stop) begin
        run_q <= 1'b0;
      end else if (start) begin
        run_q <= 1'b1;
        sel_q <= sel_i;
        div_q <= div_i;
      end
    end
  end

  assign run_o = run_q;
  assign clr_o = stop | ~run_q;
  assign sel_o = sel_q;
  assign div_o = div_q;
endmodule

// File: rtl/ftg_src_mux.sv
module ftg_src_mux
  import ftg_pkg::*;
#(
  parameter int unsigned NS = NUM_SRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic [NS-1:0] stb_i,
  input  logic [SW-1:0] sel_i,
  output logic          stb_o
);
  logic [NS-1:0] hit;

  for (genvar g = 0; g < NS; g++) begin : g_hit
    always_comb begin
      unique case (src_sel_e'(sel_i))
        SRC_AUX:           hit[g] = (g == IDX_AUX);
        SRC_MAIN:          hit[g] = (g == IDX_MAIN);
        SRC_SUB, SRC_SUB2: hit[g] = (g == IDX_SUB);
        default:           hit[g] = 1'b0;
      endcase
    end
  end

  assign stb_o = |(hit & stb_i);
endmodule

// File: rtl/ftg_divider.sv
module ftg_divider #(
  parameter int unsigned DW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          stb_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o,
  output logic [DW-1:0] cnt_o
);
  logic [DW-1:0] cnt_q;
  logic          tick_q;
  logic          wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (stb_i) begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      tick_q <= wrap;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ftg_top.sv
module ftg_top
  import ftg_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          aux_stb_i,
  input  logic          main_stb_i,
  input  logic          sub_stb_i,
  input  logic [SW-1:0] src_sel_i,
  input  logic [DW-1:0] div_i,
  input  logic          busy_i,
  input  logic          puc_i,
  input  logic          emex_i,
  output logic          tick_o
);
  logic [NUM_SRC-1:0] stb_vec;
  logic               run;
  logic               clr;
  logic [SW-1:0]      sel_q;
  logic [DW-1:0]      div_q;
  logic               stb_sel;
  logic [DW-1:0]      cnt;

  assign stb_vec[IDX_AUX]  = aux_stb_i;
  assign stb_vec[IDX_MAIN] = main_stb_i;
  assign stb_vec[IDX_SUB]  = sub_stb_i;

  ftg_ctrl #(.DW(DW), .SW(SW)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy_i),
    .puc_i (puc_i),
    .emex_i(emex_i),
    .sel_i (src_sel_i),
    .div_i (div_i),
    .run_o (run),
    .clr_o (clr),
    .sel_o (sel_q),
    .div_o (div_q)
  );

  ftg_src_mux #(.NS(NUM_SRC), .SW(SW)) u_mux (
    .stb_i(stb_vec),
    .sel_i(sel_q),
    .stb_o(stb_sel)
  );

  ftg_divider #(.DW(DW)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .stb_i (stb_sel),
    .div_i (div_q),
    .tick_o(tick_o),
    .cnt_o (cnt)
  );
endmodule

// File: rtl/ftg_sva.sv
module ftg_sva #(
  parameter int unsigned DW = 6,
  parameter int unsigned SW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          aux_stb_i,
  input logic          main_stb_i,
  input logic          sub_stb_i,
  input logic          busy_i,
  input logic          puc_i,
  input logic          emex_i,
  input logic          tick_o,
  input logic          run,
  input logic [SW-1:0] sel_q,
  input logic [DW-1:0] div_q,
  input logic [DW-1:0] cnt
);
  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !tick_o);

  p_puc_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    puc_i |=> (!tick_o && !run));

  p_emex_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emex_i |=> (!tick_o && !run));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= div_q);

  p_tick_needs_stb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(aux_stb_i | main_stb_i | sub_stb_i));

  p_cfg_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run)) |-> ($stable(sel_q) && $stable(div_q)));

  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && $past(busy_i) && busy_i) |=> !run);
endmodule

bind ftg_top ftg_sva #(.DW(DW), .SW(SW)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .aux_stb_i (aux_stb_i),
  .main_stb_i(main_stb_i),
  .sub_stb_i (sub_stb_i),
  .busy_i    (busy_i),
  .puc_i     (puc_i),
  .emex_i    (emex_i),
  .tick_o    (tick_o),
  .run       (run),
  .sel_q     (sel_q),
  .div_q     (div_q),
  .cnt       (cnt)
);

// File: tb/sim_ftg_top.sv
module sim_ftg_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       aux_stb_i = 1'b0, main_stb_i = 1'b0, sub_stb_i = 1'b0;
  logic [1:0] src_sel_i = 2'b00;
  logic [5:0] div_i = 6'd0;
  logic       busy_i = 1'b0, puc_i = 1'b0, emex_i = 1'b0;
  logic       tick_o;

  int    n_chk = 0, n_fail = 0;
  int    ph = 0;
  string cur_req = "R1";
  bit    stb_on = 1'b0;

  // reference model state
  bit m_busy_prev = 0, m_run = 0, m_tick = 0;
  int m_cnt = 0, m_sel = 0, m_div = 0;
  int tick_dut = 0, tick_ref = 0;

  always #10 clk_i = ~clk_i;

  ftg_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .aux_stb_i(aux_stb_i), .main_stb_i(main_stb_i), .sub_stb_i(sub_stb_i),
    .src_sel_i(src_sel_i), .div_i(div_i),
    .busy_i(busy_i), .puc_i(puc_i), .emex_i(emex_i),
    .tick_o(tick_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // strobes: main every cycle, sub every 3rd, aux every 5th
  always @(negedge clk_i) begin
    ph <= ph + 1;
    main_stb_i <= stb_on;
    sub_stb_i  <= stb_on && ((ph % 3) == 0);
    aux_stb_i  <= stb_on && ((ph % 5) == 0);
  end

  // behavioural reference, updated at each active edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy_prev = 0; m_run = 0; m_tick = 0; m_cnt = 0; m_sel = 0; m_div = 0;
    end else begin
      bit s;
      case (m_sel)
        0:       s = aux_stb_i;
        1:       s = main_stb_i;
        default: s = sub_stb_i;
      endcase
      if (!m_run || !busy_i || puc_i || emex_i) begin
        m_cnt = 0; m_tick = 0;
      end else if (s) begin
        m_cnt = m_cnt + 1;
        m_tick = (m_cnt == m_div + 1);
        if (m_tick) m_cnt = 0;
      end else begin
        m_tick = 0;
      end
      if (puc_i || emex_i || !busy_i) m_run = 0;
      else if (!m_busy_prev) begin
        m_run = 1; m_sel = int'(src_sel_i); m_div = int'(div_i);
      end
      m_busy_prev = busy_i;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    check(cur_req, int'(tick_o), int'(m_tick));
    if (tick_o) tick_dut++;
    if (m_tick) tick_ref++;
  end

  task automatic run_op(input string req, input logic [1:0] sel,
                        input logic [5:0] dv, input int cyc);
    @(negedge clk_i);
    cur_req = req; src_sel_i = sel; div_i = dv; busy_i = 1'b1;
    repeat (cyc) @(negedge clk_i);
    busy_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk_i);
        check("R1", int'(tick_o), 0);
        rst_ni = 1'b1;
        stb_on = 1'b1;
        repeat (10) @(negedge clk_i);
        check("R1", int'(tick_o), 0);

        run_op("R2", 2'b00, 6'd1, 60);
        run_op("R2", 2'b01, 6'd1, 60);
        run_op("R2", 2'b10, 6'd1, 60);
        run_op("R2", 2'b11, 6'd1, 60);
        run_op("R8", 2'b01, 6'd0, 20);
        run_op("R3", 2'b01, 6'd5, 50);
        run_op("R3", 2'b01, 6'd63, 200);
        run_op("R3", 2'b10, 6'd63, 400);
        // phase restart: two short runs back to back
        run_op("R4", 2'b01, 6'd5, 9);
        run_op("R4", 2'b01, 6'd5, 14);

        // R5: change settings mid-run
        @(negedge clk_i);
        cur_req = "R5"; src_sel_i = 2'b01; div_i = 6'd3; busy_i = 1'b1;
        repeat (10) @(negedge clk_i);
        src_sel_i = 2'b00; div_i = 6'd0;
        repeat (40) @(negedge clk_i);
        busy_i = 1'b0;
        repeat (4) @(negedge clk_i);

        // R6: power-up clear mid-run, busy stays high
        @(negedge clk_i);
        cur_req = "R6"; src_sel_i = 2'b01; div_i = 6'd2; busy_i = 1'b1;
        repeat (10) @(negedge clk_i);
        puc_i = 1'b1;
        @(negedge clk_i);
        puc_i = 1'b0;
        tick_dut = 0;
        repeat (30) @(negedge clk_i);
        check("R6", tick_dut, 0);
        busy_i = 1'b0;
        repeat (3) @(negedge clk_i);
        run_op("R6", 2'b01, 6'd2, 20);

        // R7: emergency exit mid-run
        @(negedge clk_i);
        cur_req = "R7"; src_sel_i = 2'b10; div_i = 6'd1; busy_i = 1'b1;
        repeat (15) @(negedge clk_i);
        emex_i = 1'b1;
        @(negedge clk_i);
        emex_i = 1'b0;
        tick_dut = 0;
        repeat (30) @(negedge clk_i);
        check("R7", tick_dut, 0);
        busy_i = 1'b0;
        repeat (3) @(negedge clk_i);
        tick_dut = 0; tick_ref = 0;
        run_op("R7", 2'b10, 6'd1, 30);
        check("R7", tick_dut, tick_ref);
        check("R7", (tick_dut > 0) ? 1 : 0, 1);

        // R4: idle, no ticks while busy low
        cur_req = "R4";
        tick_dut = 0;
        repeat (20) @(negedge clk_i);
        check("R4", tick_dut, 0);
      end
      begin
        repeat (20000) @(negedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule